// File: doc/BRIEF.md
# Audio Master-Clock Ratio and Speed Detector

This block sits in front of an audio converter datapath and works out, without any software setup, how the incoming master clock relates to the frame (left/right) clock. It runs entirely on a free-running reference clock. Both audio clocks reach it as asynchronous levels. They pass through two-flop synchronisers, and their edges are then counted. For each frame period (frame-clock rising edge to rising edge) it counts master-clock rising edges and matches the count against the supported multiples of the sample rate. The same interval is also measured in reference-clock cycles, and that length settles whether the stream runs at normal, double or quad speed.

A ratio is taken only when two back-to-back frame measurements agree to within one master-clock cycle and the ratio/speed pairing is legal. Until then, and whenever a measurement fails to match, the output samples are forced to zero. If both audio clocks go quiet for a programmable number of reference cycles, the block enters power-save and mutes. It leaves power-save once both clocks are toggling again, then relocks. Out of reset it stays in power-save until both clocks have been seen.

Top module: `clk_ratio_detect`

## Requirements
- R1: After reset, powerSave is 1, locked is 0, ratioCode is 0 and dataOut is zero. powerSave stays 1 while only one of the two audio clocks toggles.
- R2: ratioCode encodes the accepted master-clock edge count per frame period: 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1152, 0=none. A count matches when it is within TOL (default 2) of the nominal value.
- R3: locked rises only on a frame boundary. It needs two consecutive frame counts that differ by at most 1 and classify to a legal pairing. One complete frame after clocks start is not enough.
- R4: For ratio 256 or 384, speedCode is 0 (normal) when the frame period is at least NORM_MIN_REF reference cycles, and 1 (double) when it is at least DBL_MIN_REF but shorter than NORM_MIN_REF. A shorter frame is illegal.
- R5: Ratios 128 and 192 are legal only when the frame period is shorter than DBL_MIN_REF, and then give speedCode 2 (quad).
- R6: Ratios 512, 768 and 1152 are legal only when the frame period is at least NORM_MIN_REF, and give speedCode 0.
- R7: A count that matches no ratio, or an illegal ratio/speed pairing, clears locked and sets ratioCode to 0.
- R8: dataOut equals dataIn one cycle after locked is 1. It is zero one cycle after locked is 0.
- R9: When both audio clocks have shown no edge for STOP_CYC reference cycles, powerSave becomes 1 and locked becomes 0. A gap shorter than STOP_CYC does not trigger it.
- R10: Once both clocks toggle again, powerSave returns to 0 and the block relocks to the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| mclkIn | input | 1 | Asynchronous master clock level |
| lrckIn | input | 1 | Asynchronous frame (left/right) clock level |
| dataIn | input | DATA_W | Sample data to pass or mute |
| dataOut | output | DATA_W | Sample data, zero when muted |
| ratioCode | output | 3 | Detected master-clock ratio code |
| speedCode | output | 2 | 0 normal, 1 double, 2 quad |
| locked | output | 1 | Ratio accepted and stable |
| powerSave | output | 1 | Both clocks absent, output muted |

## Verification
The bench uses the default parameters: STOP_CYC 4096, NORM_MIN_REF 3456, DBL_MIN_REF 1728, TOL 2. It scales time so that a normal-speed frame lasts 4608 reference cycles, a double-speed frame 2304 and a quad-speed frame 1152. Every supported ratio then maps to a whole number of reference cycles per master-clock period (between 4 and 18), and each speed band lands well clear of both thresholds. With these values all seven ratios, both illegal pairings and a full stop/restart cycle fit in one short run. A normal-speed half frame (2304 cycles) is also short enough that the 4096-cycle stop timeout never fires on a live clock.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    RAT_NONE = 3'd0, RAT_128 = 3'd1, RAT_192 = 3'd2, RAT_256 = 3'd3,
    RAT_384  = 3'd4, RAT_512 = 3'd5, RAT_768 = 3'd6, RAT_1152 = 3'd7
  } ratio_e;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0, SPD_DOUBLE = 2'd1, SPD_QUAD = 2'd2
  } speed_e;

  // strobes handed from the datapath to the control
  typedef struct packed {
    logic frameEnd;
    logic mclkStop;
    logic lrckStop;
  } dpStrobes_t;

  function automatic int ratioNominal(input ratio_e r);
    case (r)
      RAT_128:  return 128;
      RAT_192:  return 192;
      RAT_256:  return 256;
      RAT_384:  return 384;
      RAT_512:  return 512;
      RAT_768:  return 768;
      RAT_1152: return 1152;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/crd_datapath.sv
module crd_datapath
  import crd_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int MCNT_W   = 12,
  parameter int REF_W    = 14,
  parameter int STOP_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkIn,
  input  logic              lrckIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              mute,
  output logic [DATA_W-1:0] dataOut,
  output logic [MCNT_W-1:0] measMclk,
  output logic [REF_W-1:0]  measRef,
  output dpStrobes_t        strobes
);
  localparam int STALL_W = $clog2(STOP_CYC + 1);
  localparam logic [STALL_W-1:0] STALL_MAX = STALL_W'(STOP_CYC);
  localparam logic [MCNT_W-1:0]  MCNT_MAX  = '1;
  localparam logic [REF_W-1:0]   REF_MAX   = '1;

  // two synchroniser flops plus one history flop per clock
  logic [2:0] mSync, lSync;
  logic mRise, mEdge, lRise, lEdge;
  logic [MCNT_W-1:0]  mclkCnt;
  logic [REF_W-1:0]   refCnt;
  logic [STALL_W-1:0] mStall, lStall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mSync <= '0;
      lSync <= '0;
    end else begin
      mSync <= {mSync[1:0], mclkIn};
      lSync <= {lSync[1:0], lrckIn};
    end
  end

  assign mRise = mSync[1] & ~mSync[2];
  assign mEdge = mSync[1] ^ mSync[2];
  assign lRise = lSync[1] & ~lSync[2];
  assign lEdge = lSync[1] ^ lSync[2];

  // per-frame counters, captured on each frame-clock rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mclkCnt          <= '0;
      refCnt           <= '0;
      measMclk         <= '0;
      measRef          <= '0;
      strobes.frameEnd <= 1'b0;
    end else begin
      strobes.frameEnd <= lRise;
      if (lRise) begin
        measMclk <= mclkCnt;
        measRef  <= refCnt;
        mclkCnt  <= MCNT_W'(mRise);
        refCnt   <= REF_W'(1);
      end else begin
        if (mRise && mclkCnt != MCNT_MAX) mclkCnt <= mclkCnt + 1'b1;
        if (refCnt != REF_MAX) refCnt <= refCnt + 1'b1;
      end
    end
  end

  // stall timers start saturated so both clocks count as absent after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mStall <= STALL_MAX;
      lStall <= STALL_MAX;
    end else begin
      if (mEdge) mStall <= '0;
      else if (mStall != STALL_MAX) mStall <= mStall + 1'b1;
      if (lEdge) lStall <= '0;
      else if (lStall != STALL_MAX) lStall <= lStall + 1'b1;
    end
  end

  assign strobes.mclkStop = (mStall == STALL_MAX);
  assign strobes.lrckStop = (lStall == STALL_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= mute ? '0 : dataIn;
  end

endmodule

// File: rtl/crd_control.sv
module crd_control
  import crd_pkg::*;
#(
  parameter int MCNT_W       = 12,
  parameter int REF_W        = 14,
  parameter int TOL          = 2,
  parameter int NORM_MIN_REF = 3456,
  parameter int DBL_MIN_REF  = 1728
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [MCNT_W-1:0] measMclk,
  input  logic [REF_W-1:0]  measRef,
  output ratio_e            ratioQ,
  output speed_e            speedQ,
  output logic              lockedQ,
  output logic              powerSaveQ,
  output logic              mute
);
  ratio_e            candRatio;
  speed_e            candSpeed;
  logic              candLegal, agree, prevValid;
  logic [MCNT_W-1:0] prevMclk;
  int                refLen, diff, step;

  always_comb begin
    candRatio = RAT_NONE;
    for (int i = 1; i < 8; i++) begin
      diff = int'(measMclk) - ratioNominal(ratio_e'(i));
      if (diff <= TOL && diff >= -TOL) candRatio = ratio_e'(i);
    end
    refLen    = int'(measRef);
    candSpeed = SPD_NORMAL;
    candLegal = 1'b0;
    case (candRatio)
      RAT_128, RAT_192: begin
        candSpeed = SPD_QUAD;
        candLegal = (refLen < DBL_MIN_REF);
      end
      RAT_256, RAT_384: begin
        candSpeed = (refLen >= NORM_MIN_REF) ? SPD_NORMAL : SPD_DOUBLE;
        candLegal = (refLen >= DBL_MIN_REF);
      end
      RAT_512, RAT_768, RAT_1152: begin
        candSpeed = SPD_NORMAL;
        candLegal = (refLen >= NORM_MIN_REF);
      end
      default: ;
    endcase
    step  = int'(measMclk) - int'(prevMclk);
    agree = prevValid && (step <= 1) && (step >= -1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerSaveQ <= 1'b1;
      lockedQ    <= 1'b0;
      ratioQ     <= RAT_NONE;
      speedQ     <= SPD_NORMAL;
      prevMclk   <= '0;
      prevValid  <= 1'b0;
    end else begin
      if (strobes.mclkStop && strobes.lrckStop)        powerSaveQ <= 1'b1;
      else if (!strobes.mclkStop && !strobes.lrckStop) powerSaveQ <= 1'b0;

      if (powerSaveQ || strobes.lrckStop) begin
        lockedQ   <= 1'b0;
        ratioQ    <= RAT_NONE;
        prevValid <= 1'b0;
      end else if (strobes.frameEnd) begin
        prevMclk  <= measMclk;
        prevValid <= 1'b1;
        if (candLegal && agree) begin
          lockedQ <= 1'b1;
          ratioQ  <= candRatio;
          speedQ  <= candSpeed;
        end else begin
          lockedQ <= 1'b0;
          ratioQ  <= RAT_NONE;
        end
      end
    end
  end

  assign mute = ~lockedQ;

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int MCNT_W       = 12,
  parameter int REF_W        = 14,
  parameter int STOP_CYC     = 4096,
  parameter int TOL          = 2,
  parameter int NORM_MIN_REF = 3456,
  parameter int DBL_MIN_REF  = 1728
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkIn,
  input  logic              lrckIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [2:0]        ratioCode,
  output logic [1:0]        speedCode,
  output logic              locked,
  output logic              powerSave
);
  dpStrobes_t        strobes;
  logic [MCNT_W-1:0] measMclk;
  logic [REF_W-1:0]  measRef;
  logic              mute;
  ratio_e            ratioQ;
  speed_e            speedQ;

  crd_datapath #(
    .DATA_W(DATA_W), .MCNT_W(MCNT_W), .REF_W(REF_W), .STOP_CYC(STOP_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn),
    .dataIn(dataIn), .mute(mute), .dataOut(dataOut),
    .measMclk(measMclk), .measRef(measRef), .strobes(strobes)
  );

  crd_control #(
    .MCNT_W(MCNT_W), .REF_W(REF_W), .TOL(TOL),
    .NORM_MIN_REF(NORM_MIN_REF), .DBL_MIN_REF(DBL_MIN_REF)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .measMclk(measMclk),
    .measRef(measRef), .ratioQ(ratioQ), .speedQ(speedQ),
    .lockedQ(locked), .powerSaveQ(powerSave), .mute(mute)
  );

  assign ratioCode = ratioQ;
  assign speedCode = speedQ;

endmodule

// File: rtl/clk_ratio_detect_chk.sv
module clk_ratio_detect_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              locked,
  input logic              powerSave,
  input logic              frameEnd,
  input logic [2:0]        ratioCode,
  input logic [1:0]        speedCode,
  input logic [DATA_W-1:0] dataOut
);
  // R8
  mute_when_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> dataOut == '0);

  // R9
  ps_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> !locked);

  // R3
  lock_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(frameEnd));

  // R7
  lock_has_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> ratioCode != 3'd0);

  // R5
  quad_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && (ratioCode == 3'd1 || ratioCode == 3'd2)) |-> speedCode == 2'd2);

  // R6
  normal_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && ratioCode >= 3'd5) |-> speedCode == 2'd0);

endmodule

bind clk_ratio_detect clk_ratio_detect_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .locked(locked), .powerSave(powerSave),
  .frameEnd(strobes.frameEnd), .ratioCode(ratioCode),
  .speedCode(speedCode), .dataOut(dataOut)
);

// File: tb/clk_ratio_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb;
  localparam int DATA_W = 24;
  localparam logic [DATA_W-1:0] SAMPLE = 24'h5A5A5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclk = 1'b0;
  logic lrck = 1'b0;
  logic [DATA_W-1:0] dataIn = SAMPLE;
  logic [DATA_W-1:0] dataOut;
  logic [2:0] ratioCode;
  logic [1:0] speedCode;
  logic locked, powerSave;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  bit mRun = 0, lRun = 0;
  int mHi = 9, mLo = 9, lHalf = 2304;

  always #2.5 clk = ~clk;

  clk_ratio_detect u_dut (
    .clk(clk), .rstN(rstN), .mclkIn(mclk), .lrckIn(lrck), .dataIn(dataIn),
    .dataOut(dataOut), .ratioCode(ratioCode), .speedCode(speedCode),
    .locked(locked), .powerSave(powerSave)
  );

  initial begin
    forever begin
      if (mRun) begin
        mclk = 1'b1; repeat (mHi) @(negedge clk);
        mclk = 1'b0; repeat (mLo) @(negedge clk);
      end else begin
        mclk = 1'b0; @(negedge clk);
      end
    end
  end

  initial begin
    forever begin
      if (lRun) begin
        lrck = 1'b0; repeat (lHalf) @(negedge clk);
        lrck = 1'b1; repeat (lHalf) @(negedge clk);
      end else begin
        lrck = 1'b0; @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setClocks(input int hi, input int lo, input int half);
    mHi = hi; mLo = lo; lHalf = half;
    mRun = 1; lRun = 1;
  endtask

  // wait for a lock on the expected ratio, then check all outputs
  task automatic expectLock(input int hi, input int lo, input int half,
                            input int expRatio, input int expSpeed, input string spdTag);
    setClocks(hi, lo, half);
    for (int i = 0; i < 7 * 2 * half; i++) begin
      @(negedge clk);
      if (locked && ratioCode == 3'(expRatio)) break;
    end
    repeat (4) @(negedge clk);
    check(locked == 1'b1, "R3 locked", int'(locked), 1);
    check(ratioCode == 3'(expRatio), "R2 ratioCode", int'(ratioCode), expRatio);
    check(speedCode == 2'(expSpeed), spdTag, int'(speedCode), expSpeed);
    check(dataOut == SAMPLE, "R8 pass-through", int'(dataOut), int'(SAMPLE));
  endtask

  task automatic expectReject(input int hi, input int lo, input int half, input string tag);
    setClocks(hi, lo, half);
    repeat (8 * half) @(negedge clk);
    check(locked == 1'b0, tag, int'(locked), 0);
    check(ratioCode == 3'd0, "R7 ratioCode none", int'(ratioCode), 0);
    check(dataOut == '0, "R8 muted", int'(dataOut), 0);
  endtask

  task automatic testReset();
    repeat (10) @(negedge clk);
    check(powerSave == 1'b1, "R1 powerSave", int'(powerSave), 1);
    check(locked == 1'b0, "R1 locked", int'(locked), 0);
    check(ratioCode == 3'd0, "R1 ratioCode", int'(ratioCode), 0);
    check(dataOut == '0, "R1 dataOut", int'(dataOut), 0);
    mHi = 9; mLo = 9; mRun = 1;
    repeat (6000) @(negedge clk);
    check(powerSave == 1'b1, "R1 only mclk", int'(powerSave), 1);
    check(dataOut == '0, "R1 only mclk mute", int'(dataOut), 0);
  endtask

  task automatic testStopResume();
    mRun = 0; lRun = 0;
    repeat (1000) @(negedge clk);
    check(powerSave == 1'b0, "R9 not premature", int'(powerSave), 0);
    repeat (5500) @(negedge clk);
    check(powerSave == 1'b1, "R9 powerSave", int'(powerSave), 1);
    check(locked == 1'b0, "R9 unlocked", int'(locked), 0);
    check(dataOut == '0, "R9 muted", int'(dataOut), 0);
    setClocks(6, 6, 2304);
    repeat (2 * 2304) @(negedge clk);
    check(powerSave == 1'b0, "R10 powerSave cleared", int'(powerSave), 0);
    check(locked == 1'b0, "R3 not after one frame", int'(locked), 0);
    expectLock(6, 6, 2304, 4, 0, "R10 relock speed");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    expectLock(9, 9, 2304, 3, 0, "R4 256 normal");
    expectLock(3, 3, 1152, 4, 1, "R4 384 double");
    expectLock(5, 4, 576, 1, 2, "R5 128 quad");
    expectLock(3, 3, 576, 2, 2, "R5 192 quad");
    expectLock(5, 4, 2304, 5, 0, "R6 512 normal");
    expectLock(3, 3, 2304, 6, 0, "R6 768 normal");
    expectLock(2, 2, 2304, 7, 0, "R6 1152 normal");
    testStopResume();
    expectReject(8, 8, 2304, "R7 unmatched count");
    expectReject(2, 2, 1024, "R6 512 at double rejected");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule